// File: doc/BRIEF.md
# Ascending Hardware Stack Engine

This unit executes single push and pop operations against a word-addressed data memory, using a stack pointer that it owns. The stack grows toward higher addresses. A push stores the chosen operand at the word the pointer names, then moves the pointer up by one. A pop fetches the word just below the pointer, hands it to the chosen destination, then moves the pointer down by one.

A sequencer raises `start` for one cycle with the operation type and a 3-bit operand select. The engine reads or writes the register file through a simple port with a combinational read. It reaches memory through a port whose reads are synchronous. It signals the end of each operation with a one-cycle `done`.

The pointer itself is one of the selectable operands. The program counter and the condition register can also be selected, and they are reached through the same register-file port as the general registers.

Top module: `stk_engine`

## Requirements
- R1: After reset, `sp` equals the `SP_RST` parameter (default 0), and `done`, `mem_we`, `mem_re` and `rf_we` are all low.
- R2: A push (`op_pop`=0) drives `mem_we` high for exactly one cycle. In that cycle `mem_addr` equals `sp` and `mem_wdata` is the selected operand. On the following edge `sp` becomes `sp`+1.
- R3: A pop (`op_pop`=1) stores the memory word at address `sp`−1 into the selected destination, and `sp` becomes `sp`−1.
- R4: Select codes 0 to 4 are the general registers RA to RE, 6 is the program counter and 7 is the condition register. All of these are reached at `rf_rsel`/`rf_wsel` equal to the select code. Code 5 is the internal stack pointer, and the engine never drives 5 on the register-file port with `rf_we` high.
- R5: A push with select 5 stores the pointer value from before the increment, not the register-file data.
- R6: A pop with select 5 loads the fetched word into `sp`, and the decrement is discarded. `rf_we` stays low for that pop.
- R7: Pointer arithmetic wraps modulo 2^16 with no indication. A pop at `sp`=0 reads address 16'hFFFF and leaves `sp`=16'hFFFF. A push at 16'hFFFF leaves `sp`=0.
- R8: A pop presents the address with `mem_re` high in the first cycle after start. It captures `mem_rdata` and writes the destination (`rf_we`) in the second cycle, and never asserts `mem_re` and `mem_we` together.
- R9: `done` is high for exactly one cycle. For a push it rises in the second cycle after the start edge, and for a pop in the third. No memory or register write happens in the `done` cycle.
- R10: A `start` raised while an operation is in progress, including its `done` cycle, is ignored. It causes no memory access and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| op_pop | input | 1 | 0 = push, 1 = pop |
| opnd_sel | input | 3 | Operand select code |
| rf_rsel | output | 3 | Register-file read index |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wsel | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| sp | output | 16 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take two things for granted about the surroundings. First, the memory returns data exactly one cycle after `mem_re`. Second, the register file answers `rf_rsel` within the same cycle. The bench's memory and register models are built that way. The bench raises `start` only while the engine is idle, except in one deliberate test that raises it mid-operation to exercise R10. Every other stimulus waits for `done` to fall before issuing the next request. Expected pointer values, addresses and data come from a software stack model kept in the bench.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP_RD,
        ST_POP_WB,
        ST_DONE
    } stk_state_e;

    localparam logic [2:0] SEL_SP = 3'd5;
endpackage

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_pop,
    input  logic [2:0] opnd_sel,
    output stk_state_e state,
    output logic [2:0] sel,
    output logic       busy,
    output logic       done
);
    typedef struct packed {
        stk_state_e st;
        logic [2:0] sel;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (start) begin
                    fsm_d.sel = opnd_sel;
                    fsm_d.st  = op_pop ? ST_POP_RD : ST_PUSH;
                end
            end
            ST_PUSH:   fsm_d.st = ST_DONE;
            ST_POP_RD: fsm_d.st = ST_POP_WB;
            ST_POP_WB: fsm_d.st = ST_DONE;
            ST_DONE:   fsm_d.st = ST_IDLE;
            default:   fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_IDLE;
            fsm_q.sel <= 3'd0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;
    assign sel   = fsm_q.sel;
    assign busy  = (fsm_q.st != ST_IDLE);
    assign done  = (fsm_q.st == ST_DONE);
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int          DW     = 16,
    parameter logic [DW-1:0] SP_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] sp
);
    typedef struct packed {
        logic [DW-1:0] ptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)
            ptr_d.ptr = load_val;
        else if (inc)
            ptr_d.ptr = ptr_q.ptr + DW'(1);
        else if (dec)
            ptr_d.ptr = ptr_q.ptr - DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q.ptr <= SP_RST;
        else
            ptr_q <= ptr_d;
    end

    assign sp = ptr_q.ptr;
endmodule

// File: rtl/stk_route.sv
module stk_route
    import stk_pkg::*;
#(
    parameter int DW = 16
) (
    input  stk_state_e    state,
    input  logic [2:0]    sel,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] rf_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [2:0]    rf_rsel,
    output logic          rf_we,
    output logic [2:0]    rf_wsel,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_re,
    output logic          sp_inc,
    output logic          sp_dec,
    output logic          sp_load,
    output logic [DW-1:0] sp_load_val
);
    logic sel_is_sp;
    assign sel_is_sp = (sel == SEL_SP);

    always_comb begin
        rf_rsel     = sel;
        rf_wsel     = sel;
        rf_we       = 1'b0;
        rf_wdata    = mem_rdata;
        mem_addr    = sp;
        mem_we      = 1'b0;
        mem_wdata   = sel_is_sp ? sp : rf_rdata;
        mem_re      = 1'b0;
        sp_inc      = 1'b0;
        sp_dec      = 1'b0;
        sp_load     = 1'b0;
        sp_load_val = mem_rdata;
        unique case (state)
            ST_PUSH: begin
                mem_we = 1'b1;
                sp_inc = 1'b1;
            end
            ST_POP_RD: begin
                mem_re   = 1'b1;
                mem_addr = sp - DW'(1);
            end
            ST_POP_WB: begin
                if (sel_is_sp) begin
                    sp_load = 1'b1;
                end else begin
                    rf_we  = 1'b1;
                    sp_dec = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter int            DW     = 16,
    parameter logic [DW-1:0] SP_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_pop,
    input  logic [2:0]    opnd_sel,
    output logic [2:0]    rf_rsel,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [2:0]    rf_wsel,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] sp,
    output logic          done
);
    stk_state_e    state;
    logic [2:0]    sel;
    logic          busy;
    logic          sp_inc, sp_dec, sp_load;
    logic [DW-1:0] sp_load_val;

    stk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_pop   (op_pop),
        .opnd_sel (opnd_sel),
        .state    (state),
        .sel      (sel),
        .busy     (busy),
        .done     (done)
    );

    stk_ptr #(.DW(DW), .SP_RST(SP_RST)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (sp_inc),
        .dec      (sp_dec),
        .load     (sp_load),
        .load_val (sp_load_val),
        .sp       (sp)
    );

    stk_route #(.DW(DW)) u_route (
        .state       (state),
        .sel         (sel),
        .sp          (sp),
        .rf_rdata    (rf_rdata),
        .mem_rdata   (mem_rdata),
        .rf_rsel     (rf_rsel),
        .rf_we       (rf_we),
        .rf_wsel     (rf_wsel),
        .rf_wdata    (rf_wdata),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_re      (mem_re),
        .sp_inc      (sp_inc),
        .sp_dec      (sp_dec),
        .sp_load     (sp_load),
        .sp_load_val (sp_load_val)
    );
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] sp,
    input logic          rf_we,
    input logic [2:0]    rf_wsel
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !done && !mem_we && !mem_re && !rf_we); // R1
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> sp == $past(sp) + DW'(1)); // R2
    AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n) mem_re |-> mem_addr == sp - DW'(1)); // R3
    AST_NO_SP_ON_PORT: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> rf_wsel != 3'd5); // R4
    AST_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> !mem_re && !mem_we && $stable(sp)); // R8
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_we && !mem_re && !rf_we); // R9
    AST_ACCESS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mem_we || mem_re || rf_we) |-> busy && !done); // R10
endmodule

bind stk_engine stk_engine_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp       (sp),
    .rf_we    (rf_we),
    .rf_wsel  (rf_wsel)
);

// File: tb/stk_engine_bench.sv
`timescale 1ns/1ps
module stk_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_pop = 1'b0;
    logic [2:0]  opnd_sel = 3'd0;
    logic [2:0]  rf_rsel, rf_wsel;
    logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, sp;
    logic        rf_we, mem_we, mem_re, done;

    logic [15:0] regs [8];
    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    logic [15:0] exp_regs [8];
    logic [15:0] exp_sp;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stk_engine u_stk_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop), .opnd_sel(opnd_sel),
        .rf_rsel(rf_rsel), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wsel(rf_wsel),
        .rf_wdata(rf_wdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .sp(sp), .done(done)
    );

    assign rf_rdata = regs[rf_rsel];

    always @(posedge clk) begin
        if (rf_we) regs[rf_wsel] <= rf_wdata;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [2:0] s);
        logic [15:0] v;
        v = (s == 3'd5) ? exp_sp : exp_regs[s];
        @(negedge clk); start = 1'b1; op_pop = 1'b0; opnd_sel = s;
        @(negedge clk); start = 1'b0; opnd_sel = ~s;
        chk(mem_we == 1'b1, "R2 mem_we", 16'(mem_we), 16'd1);
        chk(mem_addr == exp_sp, "R2 push addr", mem_addr, exp_sp);
        chk(mem_wdata == v, (s == 3'd5) ? "R5 push sp value" : "R4 push data", mem_wdata, v);
        chk(done == 1'b0, "R9 early done", 16'(done), 16'd0);
        @(negedge clk);
        exp_mem[exp_sp[7:0]] = v;
        exp_sp = exp_sp + 16'd1;
        chk(done == 1'b1, "R9 push done", 16'(done), 16'd1);
        chk(sp == exp_sp, "R2 push sp", sp, exp_sp);
        chk(mem_we == 1'b0, "R2 single write", 16'(mem_we), 16'd0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", 16'(done), 16'd0);
    endtask

    task automatic do_pop(input logic [2:0] s);
        logic [15:0] a, v;
        a = exp_sp - 16'd1;
        v = exp_mem[a[7:0]];
        @(negedge clk); start = 1'b1; op_pop = 1'b1; opnd_sel = s;
        @(negedge clk); start = 1'b0; opnd_sel = ~s;
        chk(mem_re == 1'b1, "R8 mem_re", 16'(mem_re), 16'd1);
        chk(mem_addr == a, "R3 pop addr", mem_addr, a);
        chk(rf_we == 1'b0, "R8 no early write", 16'(rf_we), 16'd0);
        @(negedge clk);
        if (s == 3'd5) begin
            chk(rf_we == 1'b0, "R6 no rf write", 16'(rf_we), 16'd0);
        end else begin
            chk(rf_we == 1'b1 && rf_wsel == s, "R4 write index", 16'(rf_wsel), 16'(s));
            chk(rf_wdata == v, "R3 pop data", rf_wdata, v);
        end
        chk(mem_re == 1'b0, "R8 single read", 16'(mem_re), 16'd0);
        @(negedge clk);
        if (s == 3'd5) begin
            exp_sp = v;
            chk(sp == exp_sp, "R6 pop into sp", sp, exp_sp);
        end else begin
            exp_sp = a;
            exp_regs[s] = v;
            chk(sp == exp_sp, "R3 pop sp", sp, exp_sp);
            chk(regs[s] == v, "R3 dest reg", regs[s], v);
        end
        chk(done == 1'b1, "R9 pop done", 16'(done), 16'd1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done width", 16'(done), 16'd0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
            exp_mem[i] = mem[i];
        end
        for (int i = 0; i < 8; i++) begin
            regs[i] = 16'h1111 * 16'(i + 1);
            exp_regs[i] = regs[i];
        end
        regs[5] = 16'hDEAD;
        exp_sp = 16'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sp == 16'd0, "R1 sp reset", sp, 16'd0);
        chk(!done && !mem_we && !mem_re && !rf_we, "R1 outputs idle", 16'(done), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == 16'd0 && !done, "R1 after release", sp, 16'd0);

        // R7 wrap: pop at 0 reads FFFF, push at FFFF returns to 0
        do_pop(3'd0);
        chk(sp == 16'hFFFF, "R7 pop wrap", sp, 16'hFFFF);
        do_push(3'd1);
        chk(sp == 16'h0000, "R7 push wrap", sp, 16'h0000);

        // sweeps over all selects and several data patterns
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 8; i++) begin
                if (i != 5) begin
                    regs[i] = 16'(16'h1357 * (r + 3) + 16'h0F0F * i) ^ 16'(r << 12);
                    exp_regs[i] = regs[i];
                end
            end
            for (int i = 0; i < 8; i++) do_push(3'(i));
            for (int i = 0; i < 8; i++) do_pop(3'((i * 3 + r) % 8));
        end

        // R10 start while busy is ignored
        exp_sp = sp;
        do_push(3'd2);
        @(negedge clk); start = 1'b1; op_pop = 1'b0; opnd_sel = 3'd3;
        @(negedge clk); op_pop = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        begin
            logic [15:0] sp_mid;
            sp_mid = sp;
            @(negedge clk); start = 1'b1; op_pop = 1'b1; opnd_sel = 3'd4;
            @(negedge clk); start = 1'b0;
            chk(mem_re == 1'b1, "R10 pop accepted", 16'(mem_re), 16'd1);
            @(negedge clk);
            chk(sp == sp_mid, "R10 busy start ignored", sp, sp_mid);
            chk(mem_we == 1'b0 && mem_re == 1'b0, "R10 no extra access", 16'(mem_we), 16'd0);
            @(negedge clk);
            chk(sp == sp_mid - 16'd1 && done, "R10 single pop", sp, sp_mid - 16'd1);
            @(negedge clk);
            @(negedge clk);
            chk(sp == sp_mid - 16'd1 && !mem_re && !mem_we, "R10 nothing queued", sp, sp_mid - 16'd1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule